// File: doc/BRIEF.md
# Binary Image Projection Counter Arrays

The block builds the three projections of a binary image in one pass while the image is shifted out of its store. Each beat carries one whole image column, one bit per row, bit r being row r. Three sets of counters accumulate at the same time. A counter per row adds its own bit. A counter per column adds the number of set bits in the beat. A counter per anti-diagonal bin adds the bit of row r into bin r + c, where c is the column position of the beat. The column position is held inside the block. It starts at zero and steps once for every accepted beat.

A start pulse clears all counts and the column position. A read request then streams every count out of one result port, one word per cycle, tagged with a kind code and an index. The same port can instead echo each accepted image column, so the image can be passed on while it is counted. A select input picks between the two uses.

Top module: `binproj_top`

## Requirements
- R1: After reset, and on every cycle with no result word, res_valid is 0 and res_kind, res_idx and res_data are all 0.
- R2: Row bin r holds the number of accepted beats in which bit r of pix_col was 1.
- R3: Column bin c holds the number of set bits in the beat accepted at column position c.
- R4: There are ROWS+COLS-1 diagonal bins. A set bit of row r in the beat at column position c adds one to diagonal bin r+c.
- R5: A read_go accepted while idle starts a readout on the next cycle. The readout gives ROWS+COLS+ROWS+COLS-1 consecutive words: row bins 0 upward (res_kind 0), then column bins (res_kind 1), then diagonal bins (res_kind 2). res_idx is the index inside the bin's own array, and res_data holds the count zero-extended.
- R6: start clears all counts and the column position, ends any readout, and overrides every other input in the same cycle. The cycle after start shows no result word.
- R7: With out_sel=0, an accepted beat appears on the next cycle with res_kind 3, res_idx equal to its column position and res_data[r] equal to row r. With out_sel=1 there is no echo. Counting takes place in both settings.
- R8: A beat is ignored, neither counted nor echoed, while a readout is running, in a cycle where read_go is high, or once COLS beats have been accepted since the last start. A read_go that arrives while a readout is running is ignored.
- R9: No counter overflows. With an all-ones image, row bins read COLS, column bins read ROWS, and diagonal bin d reads the number of (r,c) pairs with r+c=d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear counts and column position, end readout |
| out_sel | input | 1 | 0: echo image columns, 1: no echo |
| pix_valid | input | 1 | A column beat is present |
| pix_col | input | ROWS | Column pixels, bit r is row r |
| read_go | input | 1 | Begin streaming all counts |
| res_valid | output | 1 | Result word present |
| res_kind | output | 2 | 0 row, 1 column, 2 diagonal, 3 image column |
| res_idx | output | clog2(ROWS+COLS-1) | Index of the bin or column |
| res_data | output | max(ROWS, count width) | Count, or image column bits |

## Verification
The cases that are hardest to reach from the ports are the overlaps: a beat that arrives while a readout is running, a beat in the same cycle as read_go, a second read_go during a readout, a start that cuts a readout short, and beats after the column limit. The stimulus steers each of these on purpose. A behavioural model, which keeps plain integer bins and a word pointer, tracks every case and is compared with all output fields on every cycle. An all-ones image drives every bin to its largest value, and random images exercise the diagonal mapping.

// File: rtl/binproj_pkg.sv
package binproj_pkg;
  typedef enum logic [1:0] {
    K_ROW  = 2'd0,
    K_COL  = 2'd1,
    K_DIAG = 2'd2,
    K_IMG  = 2'd3
  } res_kind_e;
endpackage

// File: rtl/binproj_rowcnt.sv
module binproj_rowcnt #(
  parameter int ROWS = 8,
  parameter int CW   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     acc,
  input  logic [ROWS-1:0]          bits,
  output logic [ROWS-1:0][CW-1:0]  cnt
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic          en;
    logic [CW-1:0] nxt;

    always_comb begin
      en  = clr | (acc & bits[r]);
      nxt = clr ? '0 : cnt[r] + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cnt[r] <= '0;
      else if (en) cnt[r] <= nxt;
    end
  end
endmodule

// File: rtl/binproj_coldiag.sv
module binproj_coldiag #(
  parameter int ROWS = 8,
  parameter int COLS = 12,
  parameter int CW   = 4,
  parameter int PW   = 4,
  localparam int NDG = ROWS + COLS - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    acc,
  input  logic [PW-1:0]           pos,
  input  logic [ROWS-1:0]         bits,
  output logic [COLS-1:0][CW-1:0] col_cnt,
  output logic [NDG-1:0][CW-1:0]  dg_cnt
);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int r = 0; r < ROWS; r++) ones = ones + CW'(bits[r]);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic          en;
    logic [CW-1:0] nxt;

    always_comb begin
      en  = clr | (acc & (int'(pos) == c));
      nxt = clr ? '0 : col_cnt[c] + ones;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  col_cnt[c] <= '0;
      else if (en) col_cnt[c] <= nxt;
    end
  end

  for (genvar d = 0; d < NDG; d++) begin : g_dg
    logic          hit;
    logic          en;
    logic [CW-1:0] nxt;

    always_comb begin
      hit = 1'b0;
      for (int r = 0; r < ROWS; r++)
        if (int'(pos) + r == d) hit = hit | bits[r];
      en  = clr | (acc & hit);
      nxt = clr ? '0 : dg_cnt[d] + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dg_cnt[d] <= '0;
      else if (en) dg_cnt[d] <= nxt;
    end
  end
endmodule

// File: rtl/binproj_readout.sv
module binproj_readout
  import binproj_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 12,
  parameter int CW   = 4,
  localparam int NDG = ROWS + COLS - 1,
  localparam int NB  = ROWS + COLS + NDG,
  localparam int RW  = $clog2(NB),
  localparam int IW  = $clog2(NDG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    go,
  input  logic [ROWS-1:0][CW-1:0] row_cnt,
  input  logic [COLS-1:0][CW-1:0] col_cnt,
  input  logic [NDG-1:0][CW-1:0]  dg_cnt,
  output logic                    busy,
  output res_kind_e               kind,
  output logic [IW-1:0]           idx,
  output logic [CW-1:0]           data
);
  logic [RW-1:0] ptr, ptr_n;
  logic          busy_n;

  always_comb begin
    busy_n = busy;
    ptr_n  = ptr;
    if (clr) begin
      busy_n = 1'b0;
      ptr_n  = '0;
    end else if (busy) begin
      if (ptr == RW'(NB - 1)) begin
        busy_n = 1'b0;
        ptr_n  = '0;
      end else begin
        ptr_n = ptr + RW'(1);
      end
    end else if (go) begin
      busy_n = 1'b1;
      ptr_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ptr  <= '0;
    end else begin
      busy <= busy_n;
      ptr  <= ptr_n;
    end
  end

  always_comb begin
    kind = K_ROW;
    idx  = '0;
    data = '0;
    for (int i = 0; i < ROWS; i++)
      if (int'(ptr) == i) begin
        kind = K_ROW;  idx = IW'(i); data = row_cnt[i];
      end
    for (int i = 0; i < COLS; i++)
      if (int'(ptr) == ROWS + i) begin
        kind = K_COL;  idx = IW'(i); data = col_cnt[i];
      end
    for (int i = 0; i < NDG; i++)
      if (int'(ptr) == ROWS + COLS + i) begin
        kind = K_DIAG; idx = IW'(i); data = dg_cnt[i];
      end
  end
endmodule

// File: rtl/binproj_top.sv
module binproj_top
  import binproj_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 12,
  localparam int NDG = ROWS + COLS - 1,
  localparam int MX  = (ROWS > COLS) ? ROWS : COLS,
  localparam int CW  = $clog2(MX + 1),
  localparam int DW  = (ROWS > CW) ? ROWS : CW,
  localparam int IW  = $clog2(NDG),
  localparam int PW  = $clog2(COLS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            out_sel,
  input  logic            pix_valid,
  input  logic [ROWS-1:0] pix_col,
  input  logic            read_go,
  output logic            res_valid,
  output logic [1:0]      res_kind,
  output logic [IW-1:0]   res_idx,
  output logic [DW-1:0]   res_data
);
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic                    busy, accept;
  logic [PW-1:0]           pos, pos_n;
  logic                    echo_v, echo_v_n;
  logic [ROWS-1:0]         echo_bits;
  logic [IW-1:0]           echo_idx;
  logic [ROWS-1:0][CW-1:0] row_cnt;
  logic [COLS-1:0][CW-1:0] col_cnt;
  logic [NDG-1:0][CW-1:0]  dg_cnt;
  res_kind_e               rd_kind;
  logic [IW-1:0]           rd_idx;
  logic [CW-1:0]           rd_data;

  always_comb begin
    accept   = pix_valid & ~busy & ~read_go & ~start & (int'(pos) < COLS);
    pos_n    = start ? '0 : (accept ? pos + PW'(1) : pos);
    echo_v_n = accept & ~out_sel;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      pos    <= '0;
      echo_v <= 1'b0;
    end else begin
      pos    <= pos_n;
      echo_v <= echo_v_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      echo_bits <= '0;
      echo_idx  <= '0;
    end else if (accept) begin
      echo_bits <= pix_col;
      echo_idx  <= IW'(pos);
    end
  end

  binproj_rowcnt #(.ROWS(ROWS), .CW(CW)) u_row (
    .clk(clk), .rst_n(rst_i_n), .clr(start), .acc(accept),
    .bits(pix_col), .cnt(row_cnt)
  );

  binproj_coldiag #(.ROWS(ROWS), .COLS(COLS), .CW(CW), .PW(PW)) u_cd (
    .clk(clk), .rst_n(rst_i_n), .clr(start), .acc(accept), .pos(pos),
    .bits(pix_col), .col_cnt(col_cnt), .dg_cnt(dg_cnt)
  );

  binproj_readout #(.ROWS(ROWS), .COLS(COLS), .CW(CW)) u_rd (
    .clk(clk), .rst_n(rst_i_n), .clr(start), .go(read_go),
    .row_cnt(row_cnt), .col_cnt(col_cnt), .dg_cnt(dg_cnt),
    .busy(busy), .kind(rd_kind), .idx(rd_idx), .data(rd_data)
  );

  always_comb begin
    res_valid = 1'b0;
    res_kind  = 2'd0;
    res_idx   = '0;
    res_data  = '0;
    if (busy) begin
      res_valid = 1'b1;
      res_kind  = rd_kind;
      res_idx   = rd_idx;
      res_data  = DW'(rd_data);
    end else if (echo_v) begin
      res_valid = 1'b1;
      res_kind  = K_IMG;
      res_idx   = echo_idx;
      res_data  = DW'(echo_bits);
    end
  end
endmodule

// File: rtl/binproj_chk.sv
module binproj_chk
  import binproj_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 12,
  localparam int NDG = ROWS + COLS - 1,
  localparam int MX  = (ROWS > COLS) ? ROWS : COLS,
  localparam int MN  = (ROWS < COLS) ? ROWS : COLS,
  localparam int CW  = $clog2(MX + 1),
  localparam int DW  = (ROWS > CW) ? ROWS : CW,
  localparam int IW  = $clog2(NDG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_sel,
  input logic          pix_valid,
  input logic          res_valid,
  input logic [1:0]    res_kind,
  input logic [IW-1:0] res_idx,
  input logic [DW-1:0] res_data
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_data == '0 && res_idx == '0 && res_kind == 2'd0)); // R1

  AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !res_valid); // R6

  AST_ROW_TO_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == K_ROW && int'(res_idx) == ROWS - 1 && !start)
    |=> (res_valid && res_kind == K_COL && res_idx == '0)); // R5

  AST_COL_TO_DIAG: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == K_COL && int'(res_idx) == COLS - 1 && !start)
    |=> (res_valid && res_kind == K_DIAG && res_idx == '0)); // R5

  AST_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == K_DIAG && int'(res_idx) == NDG - 1 && !start)
    |=> !res_valid); // R5

  AST_ECHO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == K_IMG) |-> $past(pix_valid && !out_sel)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_kind == K_ROW  && int'(res_data) <= COLS) ||
                   (res_kind == K_COL  && int'(res_data) <= ROWS) ||
                   (res_kind == K_DIAG && int'(res_data) <= MN) ||
                    res_kind == K_IMG)); // R9
endmodule

bind binproj_top binproj_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_sel(out_sel),
  .pix_valid(pix_valid), .res_valid(res_valid), .res_kind(res_kind),
  .res_idx(res_idx), .res_data(res_data)
);

// File: tb/sim_binproj_top.sv
`timescale 1ns/1ps
module sim_binproj_top;
  localparam int ROWS = 8;
  localparam int COLS = 12;
  localparam int NDG  = ROWS + COLS - 1;
  localparam int NB   = ROWS + COLS + NDG;
  localparam int IW   = $clog2(NDG);
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rst_n, start, out_sel, pix_valid, read_go;
  logic [ROWS-1:0] pix_col;
  logic res_valid;
  logic [1:0] res_kind;
  logic [IW-1:0] res_idx;
  logic [DW-1:0] res_data;

  always #2.5 clk = ~clk;

  binproj_top #(.ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .out_sel(out_sel),
    .pix_valid(pix_valid), .pix_col(pix_col), .read_go(read_go),
    .res_valid(res_valid), .res_kind(res_kind), .res_idx(res_idx),
    .res_data(res_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  int rc[ROWS];
  int cc[COLS];
  int dc[NDG];
  bit m_busy, m_echo;
  int m_ptr, m_col, m_echo_idx;
  logic [ROWS-1:0] m_echo_bits;

  function automatic void m_clear();
    foreach (rc[i]) rc[i] = 0;
    foreach (cc[i]) cc[i] = 0;
    foreach (dc[i]) dc[i] = 0;
    m_busy = 0; m_ptr = 0; m_col = 0; m_echo = 0;
    m_echo_idx = 0; m_echo_bits = '0;
  endfunction

  function automatic void m_step(bit st, bit sl, bit pv, logic [ROWS-1:0] b, bit g);
    bit acc;
    if (st) begin
      m_clear();
      return;
    end
    acc = pv && !m_busy && !g && (m_col < COLS);
    if (acc)
      for (int r = 0; r < ROWS; r++)
        if (b[r]) begin
          rc[r]++; cc[m_col]++; dc[r + m_col]++;
        end
    m_echo = acc && !sl;
    if (acc) begin
      m_echo_bits = b; m_echo_idx = m_col; m_col++;
    end
    if (m_busy) begin
      if (m_ptr == NB - 1) begin m_busy = 0; m_ptr = 0; end
      else m_ptr++;
    end else if (g) begin
      m_busy = 1; m_ptr = 0;
    end
  endfunction

  task automatic compare();
    logic [1:0] ek;
    int ei, ed;
    bit ev;
    string rq;
    ev = 0; ek = 0; ei = 0; ed = 0; rq = "R1";
    if (m_busy) begin
      ev = 1;
      if (m_ptr < ROWS) begin ek = 0; ei = m_ptr; ed = rc[m_ptr]; rq = "R2"; end
      else if (m_ptr < ROWS + COLS) begin
        ek = 1; ei = m_ptr - ROWS; ed = cc[ei]; rq = "R3";
      end else begin
        ek = 2; ei = m_ptr - ROWS - COLS; ed = dc[ei]; rq = "R4";
      end
    end else if (m_echo) begin
      ev = 1; ek = 3; ei = m_echo_idx; ed = int'(m_echo_bits); rq = "R7";
    end
    n_cmp++;
    if (res_valid !== ev || res_kind !== ek || int'(res_idx) != ei ||
        int'(res_data) != ed || $isunknown({res_idx, res_data})) begin
      n_bad++;
      $display("FAIL %s/%s t=%0t actual v=%0b k=%0d i=%0d d=%0d expected v=%0b k=%0d i=%0d d=%0d",
               tag, rq, $time, res_valid, res_kind, res_idx, res_data, ev, ek, ei, ed);
    end
  endtask

  task automatic cyc(bit st, bit sl, bit pv, logic [ROWS-1:0] b, bit g);
    start = st; out_sel = sl; pix_valid = pv; pix_col = b; read_go = g;
    @(posedge clk);
    m_step(st, sl, pv, b, g);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, '0, 0);
  endtask

  initial begin
    #(1_000_000);
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; out_sel = 1; pix_valid = 0; pix_col = '0; read_go = 0;
    m_clear();
    repeat (3) @(negedge clk);
    compare();                            // R1 reset state
    rst_n = 1'b1;
    idle(4);

    // R1: readout straight after reset shows all zero bins
    tag = "R1";
    cyc(0, 1, 0, '0, 1); idle(NB + 2);

    // R7: echo mode with random columns, then R2 R3 R4 R5 readout
    tag = "R7";
    cyc(1, 0, 0, '0, 0);
    for (int c = 0; c < COLS; c++) cyc(0, 0, 1, ROWS'($urandom), 0);
    idle(2);
    tag = "R5";
    cyc(0, 1, 0, '0, 1); idle(NB + 2);

    // R4: single pixels placed to hit chosen diagonal bins
    tag = "R4";
    cyc(1, 1, 0, '0, 0);
    for (int c = 0; c < COLS; c++) cyc(0, 1, 1, ROWS'(1) << (c % ROWS), 0);
    cyc(0, 1, 0, '0, 1); idle(NB + 1);

    // R7: no echo with out_sel=1, gaps between beats
    tag = "R7";
    cyc(1, 1, 0, '0, 0);
    for (int c = 0; c < 6; c++) begin
      cyc(0, 1, 1, ROWS'($urandom), 0); idle(1);
    end
    cyc(0, 1, 0, '0, 1); idle(NB + 1);

    // R6: start aborts readout, start beats a pixel and read_go
    tag = "R6";
    cyc(0, 0, 1, 8'hA5, 0);
    cyc(0, 1, 0, '0, 1); idle(10);
    cyc(1, 0, 1, 8'hFF, 1); idle(3);
    cyc(0, 1, 1, 8'h0F, 0);
    cyc(0, 1, 0, '0, 1); idle(NB + 1);

    // R8: beats during readout, with read_go, past column limit; read_go while busy
    tag = "R8";
    cyc(1, 0, 0, '0, 0);
    cyc(0, 0, 1, 8'h3C, 0);
    cyc(0, 0, 0, '0, 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 8'hFF, 0);
    cyc(0, 0, 0, '0, 1);
    idle(NB);
    cyc(0, 0, 1, 8'hFF, 1); idle(NB + 1);
    for (int c = 0; c < COLS + 3; c++) cyc(0, 0, 1, ROWS'($urandom), 0);
    idle(1);
    cyc(0, 1, 0, '0, 1); idle(NB + 1);

    // R9: all-ones image drives every bin to its maximum
    tag = "R9";
    cyc(1, 1, 0, '0, 0);
    for (int c = 0; c < COLS; c++) cyc(0, 1, 1, '1, 0);
    cyc(0, 1, 0, '0, 1); idle(NB + 1);

    // R2 R3: random image back to back with readout
    tag = "R2";
    cyc(1, 0, 0, '0, 0);
    for (int c = 0; c < COLS; c++) cyc(0, c[0], 1, ROWS'($urandom), 0);
    tag = "R3";
    cyc(0, 1, 0, '0, 1); idle(NB + 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule